// File: doc/BRIEF.md
# Slot-Timed Radio Power Sequencer

This block decides, cycle by cycle, which parts of a time-slotted radio front end are powered: the frequency synthesizer, the closed phase-locked loop, the oscillator, the transmit amplifier and the receiver. It has three working modes, chosen by two configuration bits. In the direct mode the outputs follow the level of the enable line and two external power inputs. In the two serial modes the enable line carries the slot timing through its edges. A rising edge locks the loop and may start transmit. A falling edge opens the loop and may start receive. The slot then ends either on a second enable pulse or when the external oscillator power line drops.

All inputs are sampled once. The detected edges drive a state machine named by its states: `ST_DIRECT` (direct mode), `ST_BLOCKED` (reserved code), `ST_IDLE`, `ST_LOCK`, `ST_SLOT` and `ST_DRAIN`. Transitions in a serial mode:
- `ST_DIRECT`/`ST_BLOCKED` → `ST_IDLE` when a serial mode is selected.
- `ST_IDLE` → `ST_LOCK` on an enable rise.
- `ST_LOCK` → `ST_SLOT` on an enable fall.
- `ST_SLOT` → `ST_DRAIN` on an enable rise, in reduced mode only.
- `ST_DRAIN` → `ST_IDLE` on an enable fall.
- Any serial state → `ST_IDLE` while the oscillator input is low in advanced mode.

In serial modes the receive-power pin turns into an output that mirrors the internal receiver enable. Two optional timers raise ready flags once the oscillator and the transmit amplifier have been on for their settling times, which are given in microseconds and scaled by the clock rate.

Top module: `slot_power_seq`

## Requirements
- R1: The mode code {cfg_spwr, cfg_new} selects 00 direct, 01 reduced, 11 advanced and 10 reserved. ron_oe is 1 only in reduced and advanced modes. Outputs settle within three clock edges of an input or mode change.
- R2: In direct mode, synth_on and loop_closed are 1 exactly when slot_en and vco_pwr_in are both 1. loop_closed never is 1 without synth_on.
- R3: In direct mode, vco_on follows vco_pwr_in. tx_on is (not cfg_trx) and vco_pwr_in. rx_on is rx_pwr_in and vco_pwr_in.
- R4: In a serial mode, an enable rise from idle turns on synth_on, loop_closed and vco_on. It also turns on tx_on when cfg_trx is 0.
- R5: The following enable fall clears synth_on and loop_closed unless cfg_pll_hold is 1. vco_on and tx_on (when cfg_trx is 0) stay on. rx_on turns on when cfg_trx is 1, and rx_pwr_in has no effect.
- R6: In reduced mode, an enable rise during the slot turns every power output off. The block then waits for enable to go low before a new rise starts another slot.
- R7: In advanced mode, vco_on follows vco_pwr_in. While vco_pwr_in is low, all other power outputs are off and the sequence returns to idle. A second enable pulse during the slot has no effect.
- R8: ron_out equals rx_on in serial modes and is 0 in the other modes.
- R9: The reserved code holds every power output, ron_oe and ron_out at 0, whatever the inputs.
- R10: vco_ready rises after vco_on has been on for CLK_MHZ*VCO_SETTLE_US cycles, and is 0 whenever vco_on is 0.
- R11: tx_ready rises after tx_on has been on for CLK_MHZ*TX_SETTLE_US cycles, and is 0 whenever tx_on is 0.
- R12: After reset, with all inputs low, every output is 0 and the block is in direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Enable line carrying the slot timing |
| vco_pwr_in | input | 1 | External oscillator power request |
| rx_pwr_in | input | 1 | External receiver power request (direct mode) |
| cfg_new | input | 1 | Mode select, low bit |
| cfg_spwr | input | 1 | Mode select, high bit |
| cfg_trx | input | 1 | 0 = transmit slot, 1 = receive slot |
| cfg_pll_hold | input | 1 | Keep the loop closed through the slot |
| synth_on | output | 1 | Synthesizer powered |
| loop_closed | output | 1 | Phase-locked loop closed |
| vco_on | output | 1 | Oscillator powered |
| tx_on | output | 1 | Transmit amplifier powered |
| rx_on | output | 1 | Receiver powered |
| ron_oe | output | 1 | Receive-power pin acts as an output |
| ron_out | output | 1 | Value driven onto the receive-power pin |
| vco_ready | output | 1 | Oscillator settling time elapsed |
| tx_ready | output | 1 | Transmit amplifier settling time elapsed |

## Verification
The bench builds the block with CLK_MHZ=1, VCO_SETTLE_US=6 and TX_SETTLE_US=3. With these values the two ready timers expire after six and three cycles, instead of thousands. The exact cycle where each ready flag rises can then be checked on both sides of the edge, inside a full reduced-mode slot. Direct mode is covered by a table of input combinations. The serial modes, the reserved code and the advanced-mode power-down are covered by directed slot sequences.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    // Mode code is {spwr, new}
    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_REDUCED  = 2'b01,
        MODE_RESERVED = 2'b10,
        MODE_ADVANCED = 2'b11
    } op_mode_t;

    typedef enum logic [2:0] {
        ST_DIRECT,
        ST_BLOCKED,
        ST_IDLE,
        ST_LOCK,
        ST_SLOT,
        ST_DRAIN
    } seq_state_t;

    typedef struct packed {
        logic synth;
        logic loop;
        logic vco;
        logic tx;
        logic rx;
    } pwr_ctl_t;

endpackage

// File: rtl/seq_sampler.sv
module seq_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_en,
    input  logic vco_pwr_in,
    input  logic rx_pwr_in,
    output logic sen_q,
    output logic sen_rise,
    output logic sen_fall,
    output logic vco_q,
    output logic ron_q
);
    logic sen_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sen_q    <= 1'b0;
            sen_prev <= 1'b0;
            vco_q    <= 1'b0;
            ron_q    <= 1'b0;
        end else begin
            sen_q    <= slot_en;
            sen_prev <= sen_q;
            vco_q    <= vco_pwr_in;
            ron_q    <= rx_pwr_in;
        end
    end

    assign sen_rise = sen_q & ~sen_prev;
    assign sen_fall = ~sen_q & sen_prev;
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import slot_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_spwr,
    input  logic     cfg_new,
    output op_mode_t mode_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_DIRECT;
        else        mode_q <= op_mode_t'({cfg_spwr, cfg_new});
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int LIMIT  = 16,
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    generate
        if (ENABLE) begin : g_count
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (!rst_n)             cnt <= '0;
                else if (!en)           cnt <= '0;
                else if (cnt != LIM_V)  cnt <= cnt + 1'b1;
            end
            assign ready = en && (cnt == LIM_V);
        end else begin : g_bypass
            assign ready = en;
        end
    endgenerate
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import slot_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  op_mode_t mode,
    input  logic     sen_q,
    input  logic     sen_rise,
    input  logic     sen_fall,
    input  logic     vco_q,
    input  logic     ron_q,
    input  logic     trx,
    input  logic     pll_hold,
    output pwr_ctl_t ctl,
    output logic     ron_oe
);
    seq_state_t state_q, state_nx;
    logic       serial_st;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DIRECT;
        else        state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (mode)
            MODE_DIRECT:   state_nx = ST_DIRECT;
            MODE_RESERVED: state_nx = ST_BLOCKED;
            default: begin
                if (state_q == ST_DIRECT || state_q == ST_BLOCKED) begin
                    state_nx = ST_IDLE;
                end else if (mode == MODE_ADVANCED && !vco_q) begin
                    state_nx = ST_IDLE;
                end else begin
                    unique case (state_q)
                        ST_IDLE:  if (sen_rise) state_nx = ST_LOCK;
                        ST_LOCK:  if (sen_fall) state_nx = ST_SLOT;
                        ST_SLOT:  if (sen_rise && mode == MODE_REDUCED) state_nx = ST_DRAIN;
                        ST_DRAIN: if (sen_fall) state_nx = ST_IDLE;
                        default:  state_nx = ST_IDLE;
                    endcase
                end
            end
        endcase
    end

    assign serial_st = (state_q == ST_IDLE) || (state_q == ST_LOCK) ||
                       (state_q == ST_SLOT) || (state_q == ST_DRAIN);

    // Output logic
    always_comb begin
        ctl    = '0;
        ron_oe = serial_st;
        unique case (state_q)
            ST_DIRECT: begin
                ctl.synth = sen_q & vco_q;
                ctl.loop  = sen_q & vco_q;
                ctl.vco   = vco_q;
                ctl.tx    = ~trx & vco_q;
                ctl.rx    = ron_q & vco_q;
            end
            ST_LOCK: begin
                ctl.synth = 1'b1;
                ctl.loop  = 1'b1;
                ctl.vco   = 1'b1;
                ctl.tx    = ~trx;
            end
            ST_SLOT: begin
                ctl.synth = pll_hold;
                ctl.loop  = pll_hold;
                ctl.vco   = 1'b1;
                ctl.tx    = ~trx;
                ctl.rx    = trx;
            end
            default: ctl = '0;
        endcase
        if (serial_st && mode == MODE_ADVANCED) begin
            ctl.vco = vco_q;
            if (!vco_q) begin
                ctl.synth = 1'b0;
                ctl.loop  = 1'b0;
                ctl.tx    = 1'b0;
                ctl.rx    = 1'b0;
            end
        end
    end
endmodule

// File: rtl/slot_power_seq.sv
module slot_power_seq
    import slot_seq_pkg::*;
#(
    parameter int CLK_MHZ       = 125,
    parameter int VCO_SETTLE_US = 50,
    parameter int TX_SETTLE_US  = 10,
    parameter bit READY_TIMERS  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_en,
    input  logic vco_pwr_in,
    input  logic rx_pwr_in,
    input  logic cfg_new,
    input  logic cfg_spwr,
    input  logic cfg_trx,
    input  logic cfg_pll_hold,
    output logic synth_on,
    output logic loop_closed,
    output logic vco_on,
    output logic tx_on,
    output logic rx_on,
    output logic ron_oe,
    output logic ron_out,
    output logic vco_ready,
    output logic tx_ready
);
    localparam int VCO_RAW    = CLK_MHZ * VCO_SETTLE_US;
    localparam int TX_RAW     = CLK_MHZ * TX_SETTLE_US;
    localparam int VCO_CYCLES = (VCO_RAW < 1) ? 1 : VCO_RAW;
    localparam int TX_CYCLES  = (TX_RAW < 1) ? 1 : TX_RAW;

    logic     sen_q, sen_rise, sen_fall, vco_q, ron_q;
    op_mode_t mode_q;
    pwr_ctl_t ctl;

    seq_sampler u_sample (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_en    (slot_en),
        .vco_pwr_in (vco_pwr_in),
        .rx_pwr_in  (rx_pwr_in),
        .sen_q      (sen_q),
        .sen_rise   (sen_rise),
        .sen_fall   (sen_fall),
        .vco_q      (vco_q),
        .ron_q      (ron_q)
    );

    mode_decode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_spwr (cfg_spwr),
        .cfg_new  (cfg_new),
        .mode_q   (mode_q)
    );

    seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .sen_q    (sen_q),
        .sen_rise (sen_rise),
        .sen_fall (sen_fall),
        .vco_q    (vco_q),
        .ron_q    (ron_q),
        .trx      (cfg_trx),
        .pll_hold (cfg_pll_hold),
        .ctl      (ctl),
        .ron_oe   (ron_oe)
    );

    settle_timer #(.LIMIT(VCO_CYCLES), .ENABLE(READY_TIMERS)) u_vco_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctl.vco),
        .ready (vco_ready)
    );

    settle_timer #(.LIMIT(TX_CYCLES), .ENABLE(READY_TIMERS)) u_tx_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctl.tx),
        .ready (tx_ready)
    );

    assign synth_on    = ctl.synth;
    assign loop_closed = ctl.loop;
    assign vco_on      = ctl.vco;
    assign tx_on       = ctl.tx;
    assign rx_on       = ctl.rx;
    assign ron_out     = ron_oe & ctl.rx;
endmodule

// File: rtl/slot_power_seq_chk.sv
module slot_power_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_spwr,
    input logic cfg_new,
    input logic synth_on,
    input logic loop_closed,
    input logic vco_on,
    input logic tx_on,
    input logic rx_on,
    input logic ron_oe,
    input logic vco_ready,
    input logic tx_ready
);
    logic res_code;
    assign res_code = cfg_spwr && !cfg_new;

    // R2
    loop_needs_synth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_closed |-> synth_on);

    // R7
    adv_powerdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ron_oe && !vco_on) |-> !(synth_on || loop_closed || tx_on || rx_on));

    // R9
    reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_code && $past(res_code) && $past(res_code, 2)) |->
        !(synth_on || loop_closed || vco_on || tx_on || rx_on || ron_oe));

    // R10
    vco_ready_after_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_ready) |-> $past(vco_on));

    // R11
    tx_ready_after_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(tx_on));
endmodule

bind slot_power_seq slot_power_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_spwr    (cfg_spwr),
    .cfg_new     (cfg_new),
    .synth_on    (synth_on),
    .loop_closed (loop_closed),
    .vco_on      (vco_on),
    .tx_on       (tx_on),
    .rx_on       (rx_on),
    .ron_oe      (ron_oe),
    .vco_ready   (vco_ready),
    .tx_ready    (tx_ready)
);

// File: tb/slot_power_seq_tb.sv
`timescale 1ns/1ps
module slot_power_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_en = 1'b0, vco_pwr_in = 1'b0, rx_pwr_in = 1'b0;
    logic cfg_new = 1'b0, cfg_spwr = 1'b0, cfg_trx = 1'b0, cfg_pll_hold = 1'b0;
    logic synth_on, loop_closed, vco_on, tx_on, rx_on, ron_oe, ron_out, vco_ready, tx_ready;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    slot_power_seq #(.CLK_MHZ(1), .VCO_SETTLE_US(6), .TX_SETTLE_US(3), .READY_TIMERS(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .vco_pwr_in(vco_pwr_in),
        .rx_pwr_in(rx_pwr_in), .cfg_new(cfg_new), .cfg_spwr(cfg_spwr),
        .cfg_trx(cfg_trx), .cfg_pll_hold(cfg_pll_hold), .synth_on(synth_on),
        .loop_closed(loop_closed), .vco_on(vco_on), .tx_on(tx_on), .rx_on(rx_on),
        .ron_oe(ron_oe), .ron_out(ron_out), .vco_ready(vco_ready), .tx_ready(tx_ready)
    );

    wire [6:0] obs = {synth_on, loop_closed, vco_on, tx_on, rx_on, ron_oe, ron_out};

    // {trx, slot_en, vco, rx_pwr} -> {synth, loop, vco, tx, rx, oe, out}
    localparam logic [10:0] DIRECT_VEC [8] = '{
        {4'b0000, 7'b0000000},
        {4'b0110, 7'b1111000},
        {4'b1111, 7'b1110100},
        {4'b1011, 7'b0010100},
        {4'b0101, 7'b0000000},
        {4'b1010, 7'b0010000},
        {4'b0011, 7'b0011100},
        {4'b1100, 7'b0000000}
    };

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic spwr, input logic nw);
        cfg_spwr = spwr;
        cfg_new  = nw;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wait_edges(1);
        // R12 reset state
        chk("R12 reset outputs", obs, 7'b0);
        chk("R12 reset ready", {5'b0, vco_ready, tx_ready}, 7'b0);

        // R2 R3 direct mode table
        for (int i = 0; i < 8; i++) begin
            {cfg_trx, slot_en, vco_pwr_in, rx_pwr_in} = DIRECT_VEC[i][10:7];
            wait_edges(3);
            chk($sformatf("R2 R3 R8 direct row %0d", i), obs, DIRECT_VEC[i][6:0]);
        end

        // R9 reserved code
        set_mode(1'b1, 1'b0);
        cfg_trx = 1'b1; slot_en = 1'b1; vco_pwr_in = 1'b1; rx_pwr_in = 1'b1;
        wait_edges(3);
        chk("R9 reserved all off", obs, 7'b0);
        slot_en = 1'b0;
        wait_edges(3);
        chk("R9 reserved after enable fall", obs, 7'b0);

        // Reduced mode transmit slot
        set_mode(1'b0, 1'b1);
        cfg_trx = 1'b0; cfg_pll_hold = 1'b0; vco_pwr_in = 1'b0; rx_pwr_in = 1'b0;
        wait_edges(3);
        chk("R1 reduced idle pin as output", obs, 7'b0000010);
        slot_en = 1'b1;
        wait_edges(4);
        chk("R4 reduced lock tx", obs, 7'b1111010);
        chk("R11 tx not yet ready", {6'b0, tx_ready}, 7'b0);
        wait_edges(1);
        chk("R11 tx ready", {6'b0, tx_ready}, 7'b1);
        wait_edges(2);
        chk("R10 vco not yet ready", {6'b0, vco_ready}, 7'b0);
        wait_edges(1);
        chk("R10 vco ready", {6'b0, vco_ready}, 7'b1);
        slot_en = 1'b0;
        wait_edges(3);
        chk("R5 tx slot loop open", obs, 7'b0011010);
        slot_en = 1'b1;
        wait_edges(3);
        chk("R6 second pulse powers down", obs, 7'b0000010);
        chk("R10 R11 ready cleared", {5'b0, vco_ready, tx_ready}, 7'b0);
        slot_en = 1'b0;
        wait_edges(3);
        chk("R6 idle after pulse", obs, 7'b0000010);

        // Reduced mode receive slot with loop held
        cfg_trx = 1'b1; cfg_pll_hold = 1'b1; rx_pwr_in = 1'b0;
        slot_en = 1'b1;
        wait_edges(3);
        chk("R4 R6 new slot lock rx", obs, 7'b1110010);
        slot_en = 1'b0;
        wait_edges(3);
        chk("R5 R8 rx slot loop held", obs, 7'b1110111);
        slot_en = 1'b1; wait_edges(3);
        slot_en = 1'b0; wait_edges(3);
        chk("R6 rx slot ended", obs, 7'b0000010);

        // Advanced mode
        set_mode(1'b1, 1'b1);
        cfg_pll_hold = 1'b0; vco_pwr_in = 1'b1;
        wait_edges(3);
        chk("R7 advanced idle vco follows", obs, 7'b0010010);
        slot_en = 1'b1;
        wait_edges(3);
        chk("R4 advanced lock", obs, 7'b1110010);
        slot_en = 1'b0;
        wait_edges(3);
        chk("R5 R8 advanced rx slot", obs, 7'b0010111);
        slot_en = 1'b1; wait_edges(3);
        chk("R7 second pulse ignored high", obs, 7'b0010111);
        slot_en = 1'b0; wait_edges(3);
        chk("R7 second pulse ignored low", obs, 7'b0010111);
        vco_pwr_in = 1'b0;
        wait_edges(3);
        chk("R7 vco low powers down", obs, 7'b0000010);
        vco_pwr_in = 1'b1;
        wait_edges(3);
        chk("R7 back to idle", obs, 7'b0010010);
        vco_pwr_in = 1'b0;
        slot_en = 1'b1;
        wait_edges(3);
        chk("R7 rise ignored while vco low", obs, 7'b0000010);
        vco_pwr_in = 1'b1;
        wait_edges(3);
        chk("R7 no slot without rise", obs, 7'b0010010);

        // Back to direct mode
        set_mode(1'b0, 1'b0);
        slot_en = 1'b0; vco_pwr_in = 1'b0; rx_pwr_in = 1'b1;
        wait_edges(3);
        chk("R1 R8 direct pin released", obs, 7'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule